// File: doc/BRIEF.md
# Asynchronous SRAM word controller

This block sits between a clocked on-chip bus and an external asynchronous static RAM that stores 262,144 words of 16 bits behind 18 address lines. A host issues one word access at a time through a request/acknowledge handshake. The request carries a write flag, an address, write data and a per-byte mask. The controller sequences the memory's control pins, holds the data bus through a tri-state enable, and returns read data together with a one-cycle acknowledge.

The memory answers only when both of its chip enables are asserted: the first is active low and the second active high. A read drives output enable low with write enable high. A write drives write enable low with output enable high, while the controller drives the data bus. Two active-low byte selects pick which halves of the word take part in the access. The memory's access time is a parameter in nanoseconds. The controller turns it into a wait count of whole clock cycles, rounding up. Each access runs through four phases: a setup cycle, an active window as long as the wait count, a hold cycle that carries the acknowledge, and a return to idle.

Top module: `sram_word_ctrl`

## Requirements
- R1: Whenever no access is in progress, including after reset, the memory is deselected: mem_ce1_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1, both mem_bsel_n bits 1, mem_dq_oe=0, and ack=0.
- R2: A request is taken only while the controller is idle. A req_valid raised during an access starts no second access, and the memory is not written with its data.
- R3: The wait count is WAIT = ceil(ACCESS_NS / CLK_NS), which is 11 for the defaults. If req_valid is seen in cycle 0, ack is high in cycle WAIT+2 and only for that one cycle.
- R4: During a read, mem_oe_n is low for exactly WAIT cycles with mem_we_n high and mem_dq_oe low. The data on mem_dq_in in the last of those cycles appears on rsp_rdata together with ack. rsp_rdata then keeps that value until the next read completes.
- R5: During a write, mem_we_n is low for exactly WAIT cycles, mem_oe_n stays high, and mem_dq_oe is high from the setup cycle through the hold cycle. mem_dq_out carries req_wdata.
- R6: Address and byte selects are valid for one cycle with both chip enables asserted before mem_we_n falls. Address, data and byte selects stay unchanged in the cycle in which mem_we_n rises.
- R7: req_be bit 1 selects the upper byte (data bits 15:8) and drives mem_bsel_n[1] low. Bit 0 selects the lower byte (bits 7:0) and drives mem_bsel_n[0] low. A write leaves the unselected byte of the memory word unchanged.
- R8: On a read, rsp_rdata bytes whose req_be bit is 0 return 8'h00.
- R9: mem_dq_oe is never high while mem_oe_n is low. At least one full cycle with mem_dq_oe low comes before any falling edge of mem_oe_n, including a read that directly follows a write.
- R10: The two chip enables always switch together: mem_ce1_n equals the inverse of mem_ce2 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 1 upper, bit 0 lower |
| ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| mem_addr | output | 18 | Memory address lines |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_bsel_n | output | 2 | Active-low byte selects, bit 1 upper |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
Every control pin decodes straight from the state register, so a pin changes in the cycle after the clock edge that moves the state. The acknowledge follows the cycle that presented the request by WAIT+2 cycles: one setup cycle, WAIT active cycles, then the hold cycle. The bench raises a request on a falling edge, counts falling edges until ack, and expects exactly 13. It reads rsp_rdata on that same falling edge. The memory model commits a write on the falling edge where it first sees mem_we_n high again. It drives valid read data only once ACCESS_NS nanoseconds have passed since output enable fell, so a window that ends early captures garbage.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_SETUP  = 2'd1,
    ACC_ACTIVE = 2'd2,
    ACC_HOLD   = 2'd3
  } acc_state_t;

  // Whole clock cycles needed to cover the memory access time (rounded up, at least one).
  function automatic int wait_cycles(input int access_ns, input int clk_ns);
    int n;
    n = (access_ns + clk_ns - 1) / clk_ns;
    if (n < 1) n = 1;
    return n;
  endfunction

  // Counter width able to hold 0 .. n-1.
  function automatic int count_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int WAIT_CYC = 11,
  parameter int CNT_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);

  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || (cnt_q == LAST_VAL)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = run && (cnt_q == LAST_VAL);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       win_last,
  output acc_state_t state
);

  acc_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ACC_IDLE:   if (req_valid) state_d = ACC_SETUP;
      ACC_SETUP:  state_d = ACC_ACTIVE;
      ACC_ACTIVE: if (win_last) state_d = ACC_HOLD;
      ACC_HOLD:   state_d = ACC_IDLE;
      default:    state_d = ACC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ACC_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NBYTES-1:0] req_be,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [NBYTES-1:0] be_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (load) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int NBYTES = 2
) (
  input  logic              sel,
  input  logic              window,
  input  logic              wr_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [NBYTES-1:0] be_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [NBYTES-1:0] mem_bsel_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  assign mem_addr   = addr_q;
  assign mem_ce1_n  = ~sel;
  assign mem_ce2    = sel;
  assign mem_oe_n   = ~(window & ~wr_q);
  assign mem_we_n   = ~(window & wr_q);
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = sel & wr_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_bsel
    assign mem_bsel_n[b] = ~(sel & be_q[b]);
  end

endmodule

// File: rtl/sram_word_ctrl.sv
module sram_word_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int ACCESS_NS = 85,
  parameter int CLK_NS    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                ack,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce1_n,
  output logic                mem_ce2,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_bsel_n,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in
);

  localparam int NBYTES   = DATA_W / 8;
  localparam int WAIT_CYC = wait_cycles(ACCESS_NS, CLK_NS);
  localparam int CNT_W    = count_bits(WAIT_CYC);

  acc_state_t state;

  // Named internal events, also watched by the bound checker.
  logic st_idle, st_setup, st_active, st_hold;
  logic cnt_last, take_req, rd_capture, sel;

  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [NBYTES-1:0] be_q;
  logic [DATA_W-1:0] rdata_q;

  assign st_idle    = (state == ACC_IDLE);
  assign st_setup   = (state == ACC_SETUP);
  assign st_active  = (state == ACC_ACTIVE);
  assign st_hold    = (state == ACC_HOLD);
  assign sel        = st_setup | st_active | st_hold;
  assign take_req   = st_idle & req_valid;
  assign rd_capture = cnt_last & ~wr_q;

  sram_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .win_last (cnt_last),
    .state    (state)
  );

  sram_wait_cnt #(
    .WAIT_CYC(WAIT_CYC),
    .CNT_W   (CNT_W)
  ) u_wait (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_active),
    .last (cnt_last)
  );

  sram_req_latch #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NBYTES(NBYTES)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_req),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_be   (req_be),
    .wr_q     (wr_q),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .be_q     (be_q)
  );

  sram_pin_decode #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NBYTES(NBYTES)
  ) u_pins (
    .sel       (sel),
    .window    (st_active),
    .wr_q      (wr_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .be_q      (be_q),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_bsel_n(mem_bsel_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
  );

  // Read capture per byte lane; a lane left unselected returns zero.
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata_q[8*b +: 8] <= 8'h00;
      end else if (rd_capture) begin
        rdata_q[8*b +: 8] <= be_q[b] ? mem_dq_in[8*b +: 8] : 8'h00;
      end
    end
  end

  assign ack       = st_hold;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_word_ctrl_chk.sv
module sram_word_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ack,
  input logic                st_idle,
  input logic                st_setup,
  input logic                st_active,
  input logic                cnt_last,
  input logic                rd_capture,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                mem_ce1_n,
  input logic                mem_ce2,
  input logic                mem_oe_n,
  input logic                mem_we_n,
  input logic [DATA_W/8-1:0] mem_bsel_n,
  input logic [DATA_W-1:0]   mem_dq_out,
  input logic                mem_dq_oe
);

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && (&mem_bsel_n) && !mem_dq_oe && !ack));

  a_r2_setup_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    st_setup |-> $past(st_idle));

  a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r3_ack_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(st_active && cnt_last));

  a_r4_oe_closes_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> $past(cnt_last));

  a_r4_capture_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!mem_oe_n && mem_we_n && !mem_dq_oe));

  a_r5_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && mem_oe_n));

  a_r6_we_fall_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_bsel_n) && $past(!mem_ce1_n)));

  a_r6_we_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && $stable(mem_bsel_n) && !mem_ce1_n));

  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  a_r9_turnaround_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(!mem_dq_oe));

  a_r10_enables_paired: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce1_n == !mem_ce2);

endmodule

bind sram_word_ctrl sram_word_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack       (ack),
  .st_idle   (st_idle),
  .st_setup  (st_setup),
  .st_active (st_active),
  .cnt_last  (cnt_last),
  .rd_capture(rd_capture),
  .mem_addr  (mem_addr),
  .mem_ce1_n (mem_ce1_n),
  .mem_ce2   (mem_ce2),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_bsel_n(mem_bsel_n),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_word_ctrl_bench.sv
module sram_word_ctrl_bench;

  localparam int AW  = 18;
  localparam int DW  = 16;
  localparam int ACC = 85;
  localparam int TCK = 8;

  logic clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          ack;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]    mem_bsel_n;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;

  sram_word_ctrl u_sram_word_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .ack(ack), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_bsel_n(mem_bsel_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int total = 0;
  int bad   = 0;
  int exp_wait;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Wait count restated as the smallest n with n*TCK >= ACC.
  function automatic int min_cycles(input int acc, input int tck);
    int n = 0;
    while (n * tck < acc) n++;
    return n;
  endfunction

  // Behavioural memory.
  logic [DW-1:0] store [int unsigned];
  function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
    if (store.exists(int'(a))) return store[int'(a)];
    return '0;
  endfunction

  // Read drive: valid only ACC ns after output enable fell; garbage otherwise.
  logic oe_seen = 1'b1, ce_seen = 1'b1, we_seen = 1'b1;
  logic [1:0] bs_seen = 2'b11;
  logic [AW-1:0] a_seen = '0;
  time t_oe = 0;
  always begin
    #1;
    if (!oe_seen && !ce_seen && we_seen && ($time - t_oe >= ACC)) begin
      mem_dq_in[15:8] = bs_seen[1] ? 8'h96 : peek(a_seen)[15:8];
      mem_dq_in[7:0]  = bs_seen[0] ? 8'h69 : peek(a_seen)[7:0];
    end else begin
      mem_dq_in = 16'hC3C3;
    end
    if (!mem_oe_n && oe_seen) t_oe = $time;
    oe_seen = mem_oe_n;
    ce_seen = mem_ce1_n;
    we_seen = mem_we_n;
    bs_seen = mem_bsel_n;
    a_seen  = mem_addr;
  end

  // Pin monitor and write commit, sampled on falling edges.
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  int we_len = 0, oe_len = 0, low_dq = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R9 bus contention", 32'(mem_dq_oe), 32'd0);
      if (mem_ce1_n == mem_ce2)   chk(1'b0, "R10 enables split", {mem_ce1_n, mem_ce2}, 32'd2);
      if (!mem_we_n) we_len++;
      if (!mem_oe_n) oe_len++;
      if (prev_oe && !mem_oe_n)
        chk(low_dq >= 1, "R9 turnaround gap", low_dq, 32'd1);
      if (!prev_we && mem_we_n) begin
        chk(we_len == exp_wait, "R5 we low length", we_len, exp_wait);
        chk(mem_addr == prev_addr && !mem_ce1_n && mem_dq_oe, "R6 hold after we rise", mem_addr, prev_addr);
        begin
          logic [DW-1:0] w = peek(mem_addr);
          if (!mem_bsel_n[1]) w[15:8] = mem_dq_out[15:8];
          if (!mem_bsel_n[0]) w[7:0]  = mem_dq_out[7:0];
          store[int'(mem_addr)] = w;
        end
        we_len = 0;
      end
      if (!prev_oe && mem_oe_n) begin
        chk(oe_len == exp_wait, "R4 oe low length", oe_len, exp_wait);
        oe_len = 0;
      end
      low_dq  = mem_dq_oe ? 0 : low_dq + 1;
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
      prev_addr = mem_addr;
    end
  end

  task automatic check_idle(input string req);
    chk({mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_bsel_n, mem_dq_oe, ack} == 8'b1011_1100,
        req, {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_bsel_n, mem_dq_oe, ack}, 8'b1011_1100);
  endtask

  // One access; returns read data and the ack latency in cycles after the request cycle.
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] be, output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!ack && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
  endtask

  task automatic t_reset;
    check_idle("R1 reset pins");
    chk(rsp_rdata == 16'h0000, "R1 reset rdata", rsp_rdata, 16'h0000);
  endtask

  task automatic t_boundary;
    logic [DW-1:0] rd; int lat;
    access(1'b1, 18'h00000, 16'hBEEF, 2'b11, rd, lat);
    chk(lat == exp_wait + 2, "R3 write ack latency", lat, exp_wait + 2);
    @(negedge clk);
    chk(!ack, "R3 ack single cycle", ack, 0);
    check_idle("R1 idle after write");
    access(1'b1, 18'h3FFFF, 16'h1357, 2'b11, rd, lat);
    access(1'b0, 18'h00000, 16'h0000, 2'b11, rd, lat);
    chk(lat == exp_wait + 2, "R3 read ack latency", lat, exp_wait + 2);
    chk(rd == 16'hBEEF, "R4 read addr 0", rd, 16'hBEEF);
    access(1'b0, 18'h3FFFF, 16'h0000, 2'b11, rd, lat);
    chk(rd == 16'h1357, "R4 read top addr", rd, 16'h1357);
    @(negedge clk);
    check_idle("R1 idle after read");
  endtask

  task automatic t_masks;
    logic [DW-1:0] rd, exp; int lat;
    for (int m = 0; m < 4; m++) begin
      access(1'b1, 18'h00100 + 18'(m), 16'h1234, 2'b11, rd, lat);
      access(1'b1, 18'h00100 + 18'(m), 16'hABCD, 2'(m), rd, lat);
      access(1'b0, 18'h00100 + 18'(m), 16'h0000, 2'b11, rd, lat);
      exp = {(m & 2) != 0 ? 8'hAB : 8'h12, (m & 1) != 0 ? 8'hCD : 8'h34};
      chk(rd == exp, $sformatf("R7 masked write m=%0d", m), rd, exp);
      access(1'b0, 18'h00100 + 18'(m), 16'h0000, 2'(m), rd, lat);
      exp = {(m & 2) != 0 ? exp[15:8] : 8'h00, (m & 1) != 0 ? exp[7:0] : 8'h00};
      chk(rd == exp, $sformatf("R8 masked read m=%0d", m), rd, exp);
    end
  endtask

  task automatic t_busy_ignore;
    logic [DW-1:0] rd; int lat; int acks = 0;
    access(1'b1, 18'h00200, 16'h5555, 2'b11, rd, lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00300; req_wdata = 16'h7777; req_be = 2'b11;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00200; req_wdata = 16'hDEAD;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < exp_wait + 4; i++) begin
      @(negedge clk);
      if (ack) acks++;
    end
    chk(acks == 1, "R2 one ack per accepted request", acks, 1);
    access(1'b0, 18'h00200, 16'h0000, 2'b11, rd, lat);
    chk(rd == 16'h5555, "R2 busy request not written", rd, 16'h5555);
    access(1'b0, 18'h00300, 16'h0000, 2'b11, rd, lat);
    chk(rd == 16'h7777, "R2 idle request written", rd, 16'h7777);
  endtask

  task automatic t_rdata_hold;
    logic [DW-1:0] rd, keep; int lat;
    access(1'b0, 18'h00200, 16'h0000, 2'b11, keep, lat);
    access(1'b1, 18'h00400, 16'h0F0F, 2'b11, rd, lat);
    chk(rsp_rdata == keep, "R4 rdata held across write", rsp_rdata, keep);
  endtask

  task automatic t_turnaround;
    logic [DW-1:0] rd; int lat;
    access(1'b1, 18'h00500, 16'hA5A5, 2'b11, rd, lat);
    access(1'b0, 18'h00500, 16'h0000, 2'b11, rd, lat);
    chk(rd == 16'hA5A5, "R9 read right after write", rd, 16'hA5A5);
    chk(lat == exp_wait + 2, "R3 latency after turnaround", lat, exp_wait + 2);
  endtask

  initial begin
    exp_wait = min_cycles(ACC, TCK);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boundary();
    t_masks();
    t_busy_ignore();
    t_rdata_hold();
    t_turnaround();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(TCK * 150000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R3 act=hang exp=ack");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule